// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a flash controller's address window and turns ordered 32-bit writes into flash operations. Software unlocks each operation by writing fixed data values to fixed offsets in a set order. The block tracks the expected next cycle. When a sequence completes, it sets flags in a status word, updates a small register-array model of the non-volatile store, and holds a busy indication for a modelled operation time. A write that does not fit the expected cycle drops the partial sequence and raises a sequence-error flag.

Software first enters page mode and loads a 256-byte staging buffer as 32 low/high word pairs. It then commits the buffer to a page with the write-page sequence. Sectors are wiped with the erase sequence, and an erased word reads back as zero. A per-sector protection mask blocks program and erase. A password sequence lifts that protection until reset. The status word and any word of the array model are always visible on output ports.

Top module: `flash_seq_decoder`

## Requirements
- R1: After reset the status word is all zero, busy is low and every array word reads zero.
- R2: Status bit positions are busy 0, program 4, erase 5, page mode 6, sequence error 10, protection error 11 and unprotected 25; all other bits read zero. Writing 0xF5 to offset 0x5554 clears bits 4, 5, 6, 10 and 11, but not bit 25. Status bits 1 to 31 change only in a cycle that carries a write.
- R3: Writing 0x50 to offset 0x5554 sets bit 6 and restarts buffer loading at pair 0.
- R4: In page mode, a low word written to 0x55F0 and then a high word written to 0x55F4 fill the next buffer pair, for 32 pairs in all. A load outside page mode, a load out of low/high order, or a low load after 32 pairs sets bit 10.
- R5: The sequence 0xAA@0x5554, 0x55@0xAAA8, 0xA0@0x5554, 0xAA@target is accepted only in page mode. It copies the buffer into the page selected by target bits [9:8], sets bit 4, starts busy and leaves page mode. Giving the 0xA0 cycle outside page mode sets bit 10.
- R6: The sequence 0xAA@0x5554, 0x55@0xAAA8, 0x80@0x5554, 0xAA@0x5554, 0x55@0xAAA8, 0x30@target clears every word of the sector selected by target bit 9 to zero, sets bit 5 and starts busy.
- R7: The user-configuration variants use data 0xC0 instead of 0x30 on the last erase cycle, or instead of 0xA0 on the third write-page cycle. They set the same flag and start busy, but leave the array model untouched and ignore the protection mask.
- R8: Any write that does not match the next expected cycle returns the decoder to idle and sets bit 10, leaving the other flags unchanged.
- R9: Busy (port and bit 0) stays high for exactly BUSY_CYCLES cycles after the accepting cycle. A write arriving while busy is high has no effect except setting bit 10.
- R10: A normal program or erase aimed at a sector whose protMask bit is set, while bit 25 is clear, sets bit 11 only. Busy does not rise, bits 4 and 5 stay clear and the array is unchanged. A protected write-page still leaves page mode.
- R11: The unprotect sequence is 0xAA@0x5554, 0x55@0xAAA8, level@0x553C, password 1@0xAAA8, password 2@0xAAA8, 0x05@0x5558. If both passwords match, it sets bit 25, which stays set until reset and overrides protMask. A password mismatch sets bit 11 instead. A level above 2 sets bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the flash window |
| wrAddr | input | ADDR_W | Byte offset of the write within the window |
| wrData | input | 32 | Write data |
| protMask | input | NUM_SECT | Per-sector protection marks |
| rdAddr | input | ADDR_W | Byte offset of the array word to read |
| rdData | output | 32 | Array model word at rdAddr |
| status | output | 32 | Status word |
| busy | output | 1 | Modelled program or erase in progress |

## Verification
Busy expiry and command acceptance can meet in one cycle. The bench places a clear-status write exactly on the last busy cycle. It judges that the write was discarded because the program and sequence-error flags are still set once busy has fallen. It then repeats the same write one cycle later and expects every flag to clear. A second collision arises when a protected target meets the final cycle of a sequence. There, the bench checks that the protection-error flag rises while busy and the array stay untouched.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  // status bit positions
  localparam int STAT_BUSY   = 0;
  localparam int STAT_PROG   = 4;
  localparam int STAT_ERASE  = 5;
  localparam int STAT_PAGE   = 6;
  localparam int STAT_SQER   = 10;
  localparam int STAT_PROER  = 11;
  localparam int STAT_UNPROT = 25;

  // command offsets inside the flash window
  localparam logic [15:0] OFS_UNLOCK_A = 16'h5554;
  localparam logic [15:0] OFS_UNLOCK_B = 16'hAAA8;
  localparam logic [15:0] OFS_LOAD_LO  = 16'h55F0;
  localparam logic [15:0] OFS_LOAD_HI  = 16'h55F4;
  localparam logic [15:0] OFS_LEVEL    = 16'h553C;
  localparam logic [15:0] OFS_RELEASE  = 16'h5558;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_ERA3,
    ST_ERA4,
    ST_ERA5,
    ST_PGM4,
    ST_PWD3,
    ST_PWD4,
    ST_PWD5
  } seqState_t;

  typedef struct packed {
    logic setSqer;
    logic setProer;
    logic setProg;
    logic setErase;
    logic setUnprot;
    logic enterPage;
    logic leavePage;
    logic clearStat;
    logic loadLo;
    logic loadHi;
    logic commitPage;
    logic eraseSect;
    logic startBusy;
  } seqStrobe_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          NUM_SECT = 2,
  parameter int          SECT_LSB = 9,
  parameter int          SECT_W   = 1,
  parameter logic [31:0] PW1      = 32'h3A5C_0F17,
  parameter logic [31:0] PW2      = 32'h9E21_64B8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [31:0]         wrData,
  input  logic [NUM_SECT-1:0] protMask,
  input  logic                busy,
  input  logic                pageMode,
  input  logic                expectHi,
  input  logic                bufFull,
  input  logic                unprot,
  output seqStrobe_t          strb
);

  seqState_t curState, nxtState;
  logic      wpUser, nxtWpUser;
  logic      pwOk, nxtPwOk;
  logic      badCycle;

  logic isA, isB, isLo, isHi, isLvl, isRel, tgtProt;

  assign isA   = (wrAddr == ADDR_W'(OFS_UNLOCK_A));
  assign isB   = (wrAddr == ADDR_W'(OFS_UNLOCK_B));
  assign isLo  = (wrAddr == ADDR_W'(OFS_LOAD_LO));
  assign isHi  = (wrAddr == ADDR_W'(OFS_LOAD_HI));
  assign isLvl = (wrAddr == ADDR_W'(OFS_LEVEL));
  assign isRel = (wrAddr == ADDR_W'(OFS_RELEASE));
  assign tgtProt = protMask[wrAddr[SECT_LSB +: SECT_W]] && !unprot;

  always_comb begin
    strb      = '0;
    nxtState  = curState;
    nxtWpUser = wpUser;
    nxtPwOk   = pwOk;
    badCycle  = 1'b0;
    if (wrEn) begin
      if (busy) begin
        strb.setSqer = 1'b1;
      end else begin
        nxtState = ST_IDLE;
        unique case (curState)
          ST_IDLE: begin
            if (isA && wrData == 32'hAA)      nxtState = ST_UNL1;
            else if (isA && wrData == 32'h50) strb.enterPage = 1'b1;
            else if (isA && wrData == 32'hF5) strb.clearStat = 1'b1;
            else if (isLo && pageMode && !expectHi && !bufFull) strb.loadLo = 1'b1;
            else if (isHi && pageMode && expectHi) strb.loadHi = 1'b1;
            else badCycle = 1'b1;
          end
          ST_UNL1: begin
            if (isB && wrData == 32'h55) nxtState = ST_UNL2;
            else badCycle = 1'b1;
          end
          ST_UNL2: begin
            if (isA && wrData == 32'h80) nxtState = ST_ERA3;
            else if (isA && pageMode && (wrData == 32'hA0 || wrData == 32'hC0)) begin
              nxtState  = ST_PGM4;
              nxtWpUser = (wrData == 32'hC0);
            end else if (isLvl && wrData <= 32'd2) begin
              nxtState = ST_PWD3;
              nxtPwOk  = 1'b1;
            end else badCycle = 1'b1;
          end
          ST_ERA3: begin
            if (isA && wrData == 32'hAA) nxtState = ST_ERA4;
            else badCycle = 1'b1;
          end
          ST_ERA4: begin
            if (isB && wrData == 32'h55) nxtState = ST_ERA5;
            else badCycle = 1'b1;
          end
          ST_ERA5: begin
            if (wrData == 32'h30) begin
              if (tgtProt) strb.setProer = 1'b1;
              else begin
                strb.eraseSect = 1'b1;
                strb.setErase  = 1'b1;
                strb.startBusy = 1'b1;
              end
            end else if (wrData == 32'hC0) begin
              strb.setErase  = 1'b1;
              strb.startBusy = 1'b1;
            end else badCycle = 1'b1;
          end
          ST_PGM4: begin
            if (wrData == 32'hAA) begin
              strb.leavePage = 1'b1;
              if (!wpUser && tgtProt) strb.setProer = 1'b1;
              else begin
                strb.commitPage = !wpUser;
                strb.setProg    = 1'b1;
                strb.startBusy  = 1'b1;
              end
            end else badCycle = 1'b1;
          end
          ST_PWD3: begin
            if (isB) begin
              nxtState = ST_PWD4;
              nxtPwOk  = (wrData == PW1);
            end else badCycle = 1'b1;
          end
          ST_PWD4: begin
            if (isB) begin
              nxtState = ST_PWD5;
              nxtPwOk  = pwOk && (wrData == PW2);
            end else badCycle = 1'b1;
          end
          ST_PWD5: begin
            if (isRel && wrData == 32'h05) begin
              if (pwOk) strb.setUnprot = 1'b1;
              else      strb.setProer  = 1'b1;
            end else badCycle = 1'b1;
          end
          default: badCycle = 1'b1;
        endcase
        if (badCycle) strb.setSqer = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= ST_IDLE;
      wpUser   <= 1'b0;
      pwOk     <= 1'b0;
    end else begin
      curState <= nxtState;
      wpUser   <= nxtWpUser;
      pwOk     <= nxtPwOk;
    end
  end

endmodule

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BYTES  = 256,
  parameter int NUM_PAGES   = 4,
  parameter int SECT_PAGES  = 2,
  parameter int BUSY_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic [31:0]       statusWord,
  output logic              busy,
  output logic              pageMode,
  output logic              expectHi,
  output logic              bufFull,
  output logic              unprot
);

  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int PAIRS      = PAGE_WORDS / 2;
  localparam int ARR_WORDS  = PAGE_WORDS * NUM_PAGES;
  localparam int SECT_WORDS = PAGE_WORDS * SECT_PAGES;
  localparam int NUM_SECT   = NUM_PAGES / SECT_PAGES;
  localparam int ARR_W      = $clog2(ARR_WORDS);
  localparam int BUF_IW     = $clog2(PAGE_WORDS);
  localparam int PTR_W      = $clog2(PAIRS + 1);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int PAGE_W     = $clog2(NUM_PAGES);
  localparam int SECT_LSB   = PAGE_SHIFT + $clog2(SECT_PAGES);
  localparam int SECT_W     = $clog2(NUM_SECT);
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);

  logic [31:0]       pageBuf [PAGE_WORDS];
  logic [31:0]       arrMem  [ARR_WORDS];
  logic [PTR_W-1:0]  pairPtr;
  logic [CNT_W-1:0]  busyCnt;
  logic              fProg, fErase, fSqer, fProer;
  logic [BUF_IW-1:0] loIdx, hiIdx;
  logic [PAGE_W-1:0] pageSel;
  logic [SECT_W-1:0] sectSel;
  logic              unusedAddr;

  assign loIdx   = BUF_IW'({pairPtr, 1'b0});
  assign hiIdx   = BUF_IW'({pairPtr, 1'b1});
  assign pageSel = wrAddr[PAGE_SHIFT +: PAGE_W];
  assign sectSel = wrAddr[SECT_LSB +: SECT_W];
  assign bufFull = (pairPtr == PTR_W'(PAIRS));
  assign busy    = (busyCnt != '0);
  assign rdData  = arrMem[rdAddr[2 +: ARR_W]];
  assign unusedAddr = ^{wrAddr, rdAddr};

  // flags, page mode and load pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fProg <= 1'b0; fErase <= 1'b0; fSqer <= 1'b0; fProer <= 1'b0;
      unprot <= 1'b0; pageMode <= 1'b0; expectHi <= 1'b0; pairPtr <= '0;
    end else begin
      if (strb.setUnprot) unprot <= 1'b1;
      if (strb.clearStat) begin
        fProg <= 1'b0; fErase <= 1'b0; fSqer <= 1'b0; fProer <= 1'b0;
        pageMode <= 1'b0; expectHi <= 1'b0; pairPtr <= '0;
      end else begin
        if (strb.setSqer)  fSqer  <= 1'b1;
        if (strb.setProer) fProer <= 1'b1;
        if (strb.setProg)  fProg  <= 1'b1;
        if (strb.setErase) fErase <= 1'b1;
        if (strb.enterPage || strb.leavePage) begin
          pageMode <= strb.enterPage;
          expectHi <= 1'b0;
          pairPtr  <= '0;
        end else if (strb.loadLo) begin
          expectHi <= 1'b1;
        end else if (strb.loadHi) begin
          expectHi <= 1'b0;
          pairPtr  <= pairPtr + 1'b1;
        end
      end
    end
  end

  // staging buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGE_WORDS; i++) pageBuf[i] <= '0;
    end else if (strb.loadLo) begin
      pageBuf[loIdx] <= wrData;
    end else if (strb.loadHi) begin
      pageBuf[hiIdx] <= wrData;
    end
  end

  // array model: whole-page commit and whole-sector wipe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < ARR_WORDS; w++) arrMem[w] <= '0;
    end else begin
      for (int w = 0; w < ARR_WORDS; w++) begin
        if (strb.commitPage && pageSel == PAGE_W'(w / PAGE_WORDS))
          arrMem[w] <= pageBuf[w % PAGE_WORDS];
        else if (strb.eraseSect && sectSel == SECT_W'(w / SECT_WORDS))
          arrMem[w] <= '0;
      end
    end
  end

  // modelled operation time
  always_ff @(posedge clk) begin
    if (!rstN)               busyCnt <= '0;
    else if (strb.startBusy) busyCnt <= CNT_W'(BUSY_CYCLES);
    else if (busyCnt != '0)  busyCnt <= busyCnt - 1'b1;
  end

  always_comb begin
    statusWord              = '0;
    statusWord[STAT_BUSY]   = busy;
    statusWord[STAT_PROG]   = fProg;
    statusWord[STAT_ERASE]  = fErase;
    statusWord[STAT_PAGE]   = pageMode;
    statusWord[STAT_SQER]   = fSqer;
    statusWord[STAT_PROER]  = fProer;
    statusWord[STAT_UNPROT] = unprot;
  end

endmodule

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          PAGE_BYTES  = 256,
  parameter int          NUM_PAGES   = 4,
  parameter int          SECT_PAGES  = 2,
  parameter int          BUSY_CYCLES = 20,
  parameter logic [31:0] PW1         = 32'h3A5C_0F17,
  parameter logic [31:0] PW2         = 32'h9E21_64B8,
  localparam int         NUM_SECT    = NUM_PAGES / SECT_PAGES
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [31:0]         wrData,
  input  logic [NUM_SECT-1:0] protMask,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [31:0]         rdData,
  output logic [31:0]         status,
  output logic                busy
);

  localparam int SECT_LSB = $clog2(PAGE_BYTES) + $clog2(SECT_PAGES);
  localparam int SECT_W   = $clog2(NUM_SECT);

  seqStrobe_t strb;
  logic       pageMode, expectHi, bufFull, unprot;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .SECT_LSB(SECT_LSB),
    .SECT_W(SECT_W), .PW1(PW1), .PW2(PW2)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .protMask(protMask), .busy(busy), .pageMode(pageMode),
    .expectHi(expectHi), .bufFull(bufFull), .unprot(unprot), .strb(strb)
  );

  flash_seq_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
    .SECT_PAGES(SECT_PAGES), .BUSY_CYCLES(BUSY_CYCLES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .statusWord(status), .busy(busy),
    .pageMode(pageMode), .expectHi(expectHi), .bufFull(bufFull), .unprot(unprot)
  );

endmodule

// File: rtl/flash_seq_decoder_chk.sv
module flash_seq_decoder_chk #(
  parameter int BUSY_CYCLES = 20
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] status,
  input logic        busy
);

  localparam int RUN_W = $clog2(BUSY_CYCLES + 2);
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(BUSY_CYCLES)); // R9

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> status[10]); // R9

  AST_FLAGS_NEED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> (status[31:1] == $past(status[31:1]))); // R2

  AST_PROG_LEAVES_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[4]) |-> !status[6]); // R5

  AST_BUSY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (status[4] || status[5])); // R6

  AST_PROER_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[11]) |-> !$rose(busy)); // R10

  AST_UNPROT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    status[25] |=> status[25]); // R11

endmodule

bind flash_seq_decoder flash_seq_decoder_chk #(.BUSY_CYCLES(BUSY_CYCLES)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .status(status), .busy(busy)
);

// File: tb/test_flash_seq_decoder.sv
module test_flash_seq_decoder;

  localparam int          BUSY = 20;
  localparam logic [31:0] PW_A = 32'h3A5C_0F17;
  localparam logic [31:0] PW_B = 32'h9E21_64B8;
  localparam int          NV   = 27;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  protMask = '0;
  logic [15:0] rdAddr = '0;
  logic [31:0] rdData, status;
  logic        busy;
  int          nChk = 0;
  int          nFail = 0;

  always #4 clk = ~clk;

  flash_seq_decoder #(
    .ADDR_W(16), .PAGE_BYTES(256), .NUM_PAGES(4), .SECT_PAGES(2),
    .BUSY_CYCLES(BUSY), .PW1(PW_A), .PW2(PW_B)
  ) i_flash_seq_decoder (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .protMask(protMask), .rdAddr(rdAddr), .rdData(rdData),
    .status(status), .busy(busy)
  );

  // {addr, data, expected status, requirement number}
  localparam logic [87:0] VECS [NV] = '{
    {16'h5554, 32'h0000_00F5, 32'h0000_0000, 8'd2},  // R2 clear from idle
    {16'h5554, 32'h0000_0050, 32'h0000_0040, 8'd3},  // R3 enter page mode
    {16'h55F4, 32'h0000_0012, 32'h0000_0440, 8'd4},  // R4 high before low
    {16'h5554, 32'h0000_00F5, 32'h0000_0000, 8'd2},  // R2 clear leaves page mode
    {16'h55F0, 32'h0000_0077, 32'h0000_0400, 8'd4},  // R4 load outside page mode
    {16'h5554, 32'h0000_00F5, 32'h0000_0000, 8'd2},
    {16'h5554, 32'h0000_00AA, 32'h0000_0000, 8'd8},  // R8 first unlock
    {16'hAAA8, 32'h0000_0055, 32'h0000_0000, 8'd8},
    {16'h5554, 32'h0000_0099, 32'h0000_0400, 8'd8},  // R8 bad third cycle
    {16'h5554, 32'h0000_00F5, 32'h0000_0000, 8'd2},
    {16'h5554, 32'h0000_00AA, 32'h0000_0000, 8'd5},
    {16'hAAA8, 32'h0000_0055, 32'h0000_0000, 8'd5},
    {16'h5554, 32'h0000_00A0, 32'h0000_0400, 8'd5},  // R5 program outside page mode
    {16'h5554, 32'h0000_00F5, 32'h0000_0000, 8'd2},
    {16'h5554, 32'h0000_00AA, 32'h0000_0000, 8'd11},
    {16'hAAA8, 32'h0000_0055, 32'h0000_0000, 8'd11},
    {16'h553C, 32'h0000_0001, 32'h0000_0000, 8'd11},
    {16'hAAA8, 32'h1111_2222, 32'h0000_0000, 8'd11}, // wrong first password
    {16'hAAA8, PW_B,          32'h0000_0000, 8'd11},
    {16'h5558, 32'h0000_0005, 32'h0000_0800, 8'd11}, // R11 mismatch -> protection error
    {16'h5554, 32'h0000_00F5, 32'h0000_0000, 8'd2},
    {16'h5554, 32'h0000_00AA, 32'h0000_0000, 8'd11},
    {16'hAAA8, 32'h0000_0055, 32'h0000_0000, 8'd11},
    {16'h553C, 32'h0000_0003, 32'h0000_0400, 8'd11}, // R11 level out of range
    {16'h5554, 32'h0000_00F5, 32'h0000_0000, 8'd2},
    {16'hAAA8, 32'h0000_0055, 32'h0000_0400, 8'd8},  // R8 second cycle from idle
    {16'h5554, 32'h0000_00F5, 32'h0000_0000, 8'd2}
  };

  function automatic logic [31:0] pat(input int base, input int w);
    return 32'h5A00_0000 + 32'(base * 256) + 32'(w);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadPage(input int base);
    wr(16'h5554, 32'h50);
    for (int i = 0; i < 32; i++) begin
      wr(16'h55F0, pat(base, 2 * i));
      wr(16'h55F4, pat(base, 2 * i + 1));
    end
  endtask

  task automatic progSeq(input logic [15:0] a, input logic [31:0] code);
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(16'h5554, code); wr(a, 32'hAA);
  endtask

  task automatic eraseSeq(input logic [15:0] a, input logic [31:0] code);
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(16'h5554, 32'h80);
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(a, code);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bad;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 status", status, 32'h0);
    chk("R1 busy", {31'h0, busy}, 32'h0);
    rd(16'h0104, v); chk("R1 array", v, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i][87:72], VECS[i][71:40]);
      nChk++;
      if (status !== VECS[i][39:8]) begin
        nFail++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h",
                 VECS[i][7:0], i, status, VECS[i][39:8]);
      end
    end

    // R4 full buffer, R5 page program
    loadPage(1);
    chk("R4 after 32 pairs", status, 32'h40);
    wr(16'h55F0, 32'hFFFF_0000);
    chk("R4 load past end", status, 32'h440);
    progSeq(16'h0100, 32'hA0);
    chk("R5 program accepted", status, 32'h411);

    // R9 busy length and a write on the last busy cycle
    idle(BUSY - 1);
    chk("R9 busy on last cycle", {31'h0, busy}, 32'h1);
    wr(16'h5554, 32'hF5);
    chk("R9 write on last busy cycle ignored", status, 32'h410);
    chk("R9 busy fallen", {31'h0, busy}, 32'h0);
    wr(16'h5554, 32'hF5);
    chk("R2 clear after busy", status, 32'h0);

    bad = 0;
    for (int w = 0; w < 64; w++) begin
      rd(16'h0100 + 16'(4 * w), v);
      if (v !== pat(1, w)) bad++;
    end
    chk("R5 page 1 contents (bad words)", 32'(bad), 32'h0);
    rd(16'h0000, v); chk("R5 page 0 untouched", v, 32'h0);

    // R7 user-configuration variants leave the array alone
    eraseSeq(16'h0100, 32'hC0);
    chk("R7 user erase flags", status, 32'h21);
    rd(16'h0100, v); chk("R7 user erase array", v, pat(1, 0));
    idle(BUSY); wr(16'h5554, 32'hF5);
    wr(16'h5554, 32'h50); wr(16'h55F0, 32'hDEAD); wr(16'h55F4, 32'hBEEF);
    progSeq(16'h0100, 32'hC0);
    chk("R7 user program flags", status, 32'h11);
    rd(16'h0100, v); chk("R7 user program array", v, pat(1, 0));
    idle(BUSY); wr(16'h5554, 32'hF5);

    // R6 sector erase reads back zero
    eraseSeq(16'h0080, 32'h30);
    chk("R6 erase flags", status, 32'h21);
    rd(16'h0114, v); chk("R6 erased word", v, 32'h0);
    idle(BUSY); wr(16'h5554, 32'hF5);

    // R10 protection
    loadPage(2);
    progSeq(16'h0200, 32'hA0);
    chk("R5 program page 2", status, 32'h11);
    idle(BUSY); wr(16'h5554, 32'hF5);
    protMask = 2'b10;
    eraseSeq(16'h0204, 32'h30);
    chk("R10 protected erase", status, 32'h800);
    chk("R10 no busy", {31'h0, busy}, 32'h0);
    rd(16'h0208, v); chk("R10 data kept", v, pat(2, 2));
    wr(16'h5554, 32'hF5);
    wr(16'h5554, 32'h50);
    progSeq(16'h0300, 32'hA0);
    chk("R10 protected program", status, 32'h800);
    rd(16'h0300, v); chk("R10 page 3 untouched", v, 32'h0);
    wr(16'h5554, 32'hF5);

    // R11 correct unprotect overrides the mask
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(16'h553C, 32'h0);
    wr(16'hAAA8, PW_A); wr(16'hAAA8, PW_B); wr(16'h5558, 32'h05);
    chk("R11 unprotected flag", status, 32'h0200_0000);
    eraseSeq(16'h0200, 32'h30);
    chk("R11 erase after unprotect", status, 32'h0200_0021);
    rd(16'h0208, v); chk("R11 sector wiped", v, 32'h0);
    idle(BUSY);
    wr(16'h5554, 32'hF5);
    chk("R2 clear keeps unprotect", status, 32'h0200_0000);

    summary();
    $finish;
  end

endmodule